// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Stall Unit

This block sits beside the execute stage of a five-stage in-order integer pipeline. For each of the two source register numbers of the instruction now in execute, it decides where the operand value should come from. There are three choices: the value read from the register file during decode, the result held in the memory stage, or the result held in the write-back stage. The datapath multiplexers use the two select codes it returns. The block holds no state and makes its decision in the same cycle as its inputs.

The decision rests only on register numbers and on each later stage's write-enable and load flags. It does not look at whether the execute instruction really reads a given source field. A jump-and-link, for example, still receives forwarding selects for its unused fields. The block also raises a stall request when the execute instruction depends on a value that the memory stage is still fetching from data memory. A store in execute is the exception: its data operand can wait for the loaded value, so a match on that operand alone does not stall. Inserting the bubble, flushing and the multiplexers belong to the surrounding pipeline.

Top module: `fwd_unit`

## Requirements
- R1: When neither the memory stage nor the write-back stage has its write enable set, both selects are 2'b00 (register-file value from decode).
- R2: A source whose number equals the memory-stage destination, with that stage's write enable set and a non-zero destination, gets select 2'b01.
- R3: A source whose number equals the write-back destination, with that stage's write enable set, a non-zero destination and no memory-stage match, gets select 2'b10.
- R4: When the memory stage and the write-back stage both match the same source, the memory stage wins and the select is 2'b01.
- R5: A destination of register 0 never forwards, even when the source is also register 0 and write enable is set.
- R6: A stage whose write enable is clear is never a forwarding source, whatever its destination number is.
- R7: The selects depend only on register numbers and the later-stage flags. The store flag of the execute instruction never changes them.
- R8: `load_stall` is 1 when the memory stage holds a load (load flag and write enable set, non-zero destination) whose destination equals the first source (address/operand A).
- R9: For a non-store execute instruction, `load_stall` is 1 when such a memory-stage load's destination equals the second source.
- R10: For a store in execute, a memory-stage load that matches only the second source (store data) does not raise `load_stall`, and the select for that source is still 2'b01.
- R11: `load_stall` is 0 when the memory stage's load flag is set but its write enable is clear, when the load's destination is register 0, and when the only match is in write-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_AW | First source register number of the execute instruction |
| ex_src_b | input | REG_AW | Second source register number of the execute instruction |
| ex_store | input | 1 | Execute instruction writes data memory (second source is store data) |
| mem_dst | input | REG_AW | Destination register number in the memory stage |
| mem_wr_en | input | 1 | Memory-stage instruction writes the register file |
| mem_load | input | 1 | Memory-stage instruction takes its result from data memory |
| wb_dst | input | REG_AW | Destination register number in the write-back stage |
| wb_wr_en | input | 1 | Write-back instruction writes the register file |
| sel_a | output | 2 | Source select for operand A: 00 decode, 01 memory, 10 write-back |
| sel_b | output | 2 | Source select for operand B, same encoding |
| load_stall | output | 1 | Request to hold execute for one cycle because of a pending load |

## Verification
The bench targets the cases where the memory stage and the write-back stage both match one source. A design that lets the older result win would send a stale value into execute. It also targets register 0 as both source and destination, and a stage whose destination matches while its write enable is clear, as a branch does. A unit that missed either of these would forward a result that was never written. The load cases pair each operand with a store and a non-store in execute. A design that ignored the store semantics would either stall stores with no need or miss a real address dependency. A design that stalled on write-back loads or on register 0 loads would lose cycles for nothing.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  // Operand count of the instruction format: two register sources.
  localparam int unsigned NUM_SRC = 2;

  // Index of the source that carries store data for a store instruction.
  localparam int unsigned STORE_DATA_SRC = 1;

  // Operand source select encoding seen by the datapath multiplexers.
  typedef enum logic [1:0] {
    SEL_ID  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match #(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wr_en,
  output logic          hit
);

  logic dst_live;

  // Register 0 is hard-wired to zero and never produces a result worth forwarding.
  assign dst_live = wr_en && (dst != '0);
  assign hit      = dst_live && (dst == src);

endmodule

// File: rtl/fwd_operand_select.sv
module fwd_operand_select
  import fwd_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wr_en,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wr_en,
  output fwd_sel_e      sel,
  output logic          mem_hit
);

  logic wb_hit;

  fwd_stage_match #(.AW(AW)) u_mem_match (
    .src   (src),
    .dst   (mem_dst),
    .wr_en (mem_wr_en),
    .hit   (mem_hit)
  );

  fwd_stage_match #(.AW(AW)) u_wb_match (
    .src   (src),
    .dst   (wb_dst),
    .wr_en (wb_wr_en),
    .hit   (wb_hit)
  );

  // The memory stage holds the younger result, so it is checked first.
  always_comb begin
    if (mem_hit)     sel = SEL_MEM;
    else if (wb_hit) sel = SEL_WB;
    else             sel = SEL_ID;
  end

endmodule

// File: rtl/fwd_load_check.sv
module fwd_load_check
  import fwd_pkg::*;
(
  input  logic [NUM_SRC-1:0] mem_hit,
  input  logic               mem_load,
  input  logic               ex_store,
  output logic               stall
);

  logic [NUM_SRC-1:0] needed_now;

  // A store's data operand is consumed a stage later, so its load match can wait.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_need
    if (i == STORE_DATA_SRC) begin : g_data
      assign needed_now[i] = !ex_store;
    end else begin : g_addr
      assign needed_now[i] = 1'b1;
    end
  end

  assign stall = mem_load && |(mem_hit & needed_now);

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int unsigned REG_AW = 5
) (
  input  logic [REG_AW-1:0] ex_src_a,
  input  logic [REG_AW-1:0] ex_src_b,
  input  logic              ex_store,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  input  logic              mem_load,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_wr_en,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              load_stall
);

  logic [REG_AW-1:0]  src_vec [NUM_SRC];
  fwd_sel_e           sel_vec [NUM_SRC];
  logic [NUM_SRC-1:0] mem_hit_vec;

  assign src_vec[0] = ex_src_a;
  assign src_vec[1] = ex_src_b;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_op
    fwd_operand_select #(.AW(REG_AW)) u_sel (
      .src       (src_vec[i]),
      .mem_dst   (mem_dst),
      .mem_wr_en (mem_wr_en),
      .wb_dst    (wb_dst),
      .wb_wr_en  (wb_wr_en),
      .sel       (sel_vec[i]),
      .mem_hit   (mem_hit_vec[i])
    );
  end

  fwd_load_check u_load (
    .mem_hit  (mem_hit_vec),
    .mem_load (mem_load),
    .ex_store (ex_store),
    .stall    (load_stall)
  );

  assign sel_a = sel_vec[0];
  assign sel_b = sel_vec[1];

  // Checks across the select paths and the stall path.
  always_comb begin
    p_sel_legal_r2: assert ($onehot0(sel_a) && $onehot0(sel_b))
      else $error("select code 2'b11 produced");
    p_idle_sel_r1: assert (mem_wr_en || wb_wr_en || (sel_a == SEL_ID && sel_b == SEL_ID))
      else $error("forwarding with no writer present");
    p_zero_dst_r5: assert (mem_dst != '0 || wb_dst != '0 || (sel_a == SEL_ID && sel_b == SEL_ID))
      else $error("register 0 forwarded");
    p_mem_first_r4: assert (sel_a != SEL_WB || !(mem_wr_en && mem_dst != '0 && mem_dst == ex_src_a))
      else $error("older write-back result chosen over memory stage");
    p_stall_load_r8: assert (!load_stall || (mem_load && mem_wr_en))
      else $error("stall without a pending load");
    p_stall_sel_r11: assert (!load_stall || sel_a == SEL_MEM || sel_b == SEL_MEM)
      else $error("stall while no operand points at memory stage");
    p_store_data_r10: assert (!(ex_store && load_stall) || sel_a == SEL_MEM)
      else $error("store stalled on its data operand only");
  end

endmodule

// File: tb/fwd_unit_bench.sv
module fwd_unit_bench;

  localparam int unsigned AW = 5;
  localparam logic [1:0] S_ID = 2'b00, S_MEM = 2'b01, S_WB = 2'b10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst;
  logic          ex_store, mem_wr_en, mem_load, wb_wr_en;
  logic [1:0]    sel_a, sel_b;
  logic          load_stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fwd_unit #(.REG_AW(AW)) u_fwd_unit (
    .ex_src_a   (ex_src_a),
    .ex_src_b   (ex_src_b),
    .ex_store   (ex_store),
    .mem_dst    (mem_dst),
    .mem_wr_en  (mem_wr_en),
    .mem_load   (mem_load),
    .wb_dst     (wb_dst),
    .wb_wr_en   (wb_wr_en),
    .sel_a      (sel_a),
    .sel_b      (sel_b),
    .load_stall (load_stall)
  );

  // Drive on the falling edge, sample just before the next falling edge.
  task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b, input logic st,
                       input logic [AW-1:0] md, input logic mw, input logic ml,
                       input logic [AW-1:0] wd, input logic ww);
    @(negedge clk);
    ex_src_a = a; ex_src_b = b; ex_store = st;
    mem_dst = md; mem_wr_en = mw; mem_load = ml;
    wb_dst = wd; wb_wr_en = ww;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic t_reset_idle;
    // R1: during reset the pipeline is all bubbles
    chk("R1 sel_a idle", sel_a, S_ID);
    chk("R1 sel_b idle", sel_b, S_ID);
    chk("R1 stall idle", {1'b0, load_stall}, 2'b00);
    drive(5'd3, 5'd3, 1'b0, 5'd3, 1'b0, 1'b1, 5'd3, 1'b0);
    chk("R1 no writers sel_a", sel_a, S_ID);
    chk("R1 no writers sel_b", sel_b, S_ID);
  endtask

  task automatic t_mem_wb;
    drive(5'd4, 5'd9, 1'b0, 5'd4, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R2 mem fwd a", sel_a, S_MEM);
    chk("R2 untouched b", sel_b, S_ID);
    drive(5'd8, 5'd5, 1'b0, 5'd1, 1'b1, 1'b0, 5'd5, 1'b1);
    chk("R3 wb fwd b", sel_b, S_WB);
    chk("R3 untouched a", sel_a, S_ID);
  endtask

  task automatic t_priority;
    drive(5'd7, 5'd7, 1'b0, 5'd7, 1'b1, 1'b0, 5'd7, 1'b1);
    chk("R4 mem over wb a", sel_a, S_MEM);
    chk("R4 mem over wb b", sel_b, S_MEM);
    drive(5'd7, 5'd7, 1'b0, 5'd2, 1'b1, 1'b0, 5'd7, 1'b1);
    chk("R4 wb when mem misses", sel_a, S_WB);
  endtask

  task automatic t_zero;
    drive(5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1);
    chk("R5 x0 a", sel_a, S_ID);
    chk("R5 x0 b", sel_b, S_ID);
    chk("R11 x0 load no stall", {1'b0, load_stall}, 2'b00);
  endtask

  task automatic t_no_write;
    // memory stage holds a branch that names the source but writes nothing
    drive(5'd4, 5'd5, 1'b0, 5'd4, 1'b0, 1'b0, 5'd5, 1'b1);
    chk("R6 mem disabled a", sel_a, S_ID);
    chk("R6 wb enabled b", sel_b, S_WB);
    drive(5'd4, 5'd6, 1'b0, 5'd9, 1'b1, 1'b0, 5'd6, 1'b0);
    chk("R6 wb disabled b", sel_b, S_ID);
  endtask

  task automatic t_kind_blind;
    // a jump-and-link carries garbage source fields; forwarding still follows them
    drive(5'd1, 5'd5, 1'b0, 5'd1, 1'b1, 1'b0, 5'd5, 1'b1);
    chk("R7 plain a", sel_a, S_MEM);
    chk("R7 plain b", sel_b, S_WB);
    drive(5'd1, 5'd5, 1'b1, 5'd1, 1'b1, 1'b0, 5'd5, 1'b1);
    chk("R7 store a", sel_a, S_MEM);
    chk("R7 store b", sel_b, S_WB);
  endtask

  task automatic t_load;
    drive(5'd10, 5'd11, 1'b0, 5'd10, 1'b1, 1'b1, 5'd0, 1'b0);
    chk("R8 load on a", {1'b0, load_stall}, 2'b01);
    drive(5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 1'b1, 5'd0, 1'b0);
    chk("R8 store address on a", {1'b0, load_stall}, 2'b01);
    drive(5'd12, 5'd11, 1'b0, 5'd11, 1'b1, 1'b1, 5'd0, 1'b0);
    chk("R9 load on b", {1'b0, load_stall}, 2'b01);
    drive(5'd12, 5'd11, 1'b1, 5'd11, 1'b1, 1'b1, 5'd0, 1'b0);
    chk("R10 store data no stall", {1'b0, load_stall}, 2'b00);
    chk("R10 store data sel", sel_b, S_MEM);
    drive(5'd2, 5'd5, 1'b1, 5'd1, 1'b1, 1'b1, 5'd5, 1'b1);
    chk("R10 store unrelated load", {1'b0, load_stall}, 2'b00);
  endtask

  task automatic t_no_stall;
    drive(5'd13, 5'd14, 1'b0, 5'd13, 1'b0, 1'b1, 5'd0, 1'b0);
    chk("R11 load flag without write", {1'b0, load_stall}, 2'b00);
    drive(5'd13, 5'd14, 1'b0, 5'd3, 1'b1, 1'b1, 5'd13, 1'b1);
    chk("R11 wb only match", {1'b0, load_stall}, 2'b00);
    chk("R11 wb only sel", sel_a, S_WB);
    drive(5'd13, 5'd14, 1'b0, 5'd13, 1'b1, 1'b0, 5'd0, 1'b0);
    chk("R11 alu result in mem", {1'b0, load_stall}, 2'b00);
  endtask

  initial begin
    ex_src_a = '0; ex_src_b = '0; ex_store = 1'b0;
    mem_dst = '0; mem_wr_en = 1'b0; mem_load = 1'b0;
    wb_dst = '0; wb_wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    t_reset_idle();
    rst = 1'b0;
    t_mem_wb();
    t_priority();
    t_zero();
    t_no_write();
    t_kind_blind();
    t_load();
    t_no_stall();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule